// File: doc/BRIEF.md
# Serial Systematic Cyclic Encoder and Checker

This block turns a serial stream of information bits into a systematic codeword of a binary cyclic code. Bits arrive highest-order coefficient first on a valid/ready input stream. They leave unchanged, as the top K coefficients of the codeword, on a valid/ready output stream. The block then appends R check bits: the remainder of x^R·d(x) divided by the generator g(x), highest order first. A shift-register divider with feedback taps at the nonzero low coefficients of g(x) computes the remainder as the information bits pass through. The default code is the (7,4) cyclic Hamming code with g(x) = x^3 + x + 1. A parameter instead selects a standard CRC generator: CRC-12, CRC-16 (x^16+x^15+x^2+1) or the X.25 CCITT polynomial (x^16+x^12+x^5+1).

The block also has a checking mode. In that mode a received word of N = K+R bits flows into the same divider and produces no output beats. One cycle after the last bit, the block pulses a done flag and reports an error when the remainder is nonzero. The mode pin is sampled only when the first bit of a frame is accepted.

Back-pressure rules: while information bits are passing through, `s_ready` follows `m_ready`, so a beat is consumed on the input exactly when it is delivered on the output. While check bits are emitted, `s_ready` is low, and `m_valid` stays high with `m_bit` held until `m_ready` accepts it. In checking mode `s_ready` is high during the word and `m_valid` stays low. A stall on either side never alters the partial remainder.

Top module: `cyclic_enc`

## Requirements
- R1: After reset the block is at the start of a frame: `check_phase`, `chk_done` and `chk_err` are 0, and `m_valid` is 0 while `s_valid` is 0.
- R2: In encoding mode the first K output beats carry the K accepted information bits unchanged and in arrival order (d_{K-1} first). This places d_i at codeword position u_{i+R}.
- R3: After K information beats, the block emits R check bits with `check_phase` = 1 and `s_ready` = 0. The check bits are the coefficients of x^R·d(x) mod g(x), highest first, and fill positions u_{R-1}..u_0.
- R4: With the default code, d(x) = 1 (input 0,0,0,1) yields the codeword 0001011 (1 + x + x^3), and d(x) = 0 yields seven zeros.
- R5: When `m_ready` is low, no beat moves. In the information part `s_ready` is low. In the check part `m_valid` stays 1 with `m_bit` unchanged. The finished codeword equals the unstalled one.
- R6: Cycles with `s_valid` low consume nothing and do not change the codeword.
- R7: In checking mode N input beats are accepted with no output beat. One cycle after the last beat, `chk_done` is 1 for exactly one cycle with `chk_err` = 1 iff the word is not a multiple of g(x). `chk_err` is 0 whenever `chk_done` is 0.
- R8: The remainder is cleared between frames, so back-to-back frames encode independently.
- R9: The generator is a parameter. With the CCITT polynomial and K = 8, the byte 0x01 yields the check word 0x1021. The CRC-16 selection uses taps 0x8005 and the CRC-12 selection uses taps 0x80F.
- R10: A change on `mode_check` after the first bit of a frame has been accepted has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_check | input | 1 | 0 encodes, 1 checks a received word; sampled at the first beat of a frame |
| s_valid | input | 1 | Input bit valid |
| s_ready | output | 1 | Block accepts the input bit |
| s_bit | input | 1 | Input bit, highest-order coefficient first |
| m_valid | output | 1 | Output bit valid |
| m_ready | input | 1 | Downstream accepts the output bit |
| m_bit | output | 1 | Codeword bit, highest order first |
| check_phase | output | 1 | High while check bits are offered |
| chk_done | output | 1 | One-cycle pulse ending a checking-mode word |
| chk_err | output | 1 | Nonzero remainder, valid with `chk_done` |

## Verification
The bench targets the single-term info word d(x) = 1. A divider with misplaced taps or the wrong feedback order gives a check part other than 011 there. It stalls the output while check bits are being shifted: a divider that shifts regardless of `m_ready` loses a check bit, and one that pauses the input side late drops or duplicates an information bit. It sends back-to-back frames, which expose a remainder that is not cleared. It flips the mode pin mid-frame, which exposes a design that samples the mode on every beat. It checks a clean and a single-bit-corrupted word, which expose an inverted error flag or a done pulse that lands on the wrong cycle.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [1:0] {
    PH_DATA   = 2'd0,
    PH_CHECK  = 2'd1,
    PH_REPORT = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SEL_HAM7  = 2'd0,
    SEL_CRC12 = 2'd1,
    SEL_CRC16 = 2'd2,
    SEL_CCITT = 2'd3
  } code_sel_t;

  // Degree of the generator for each selection.
  function automatic int sel_degree(input code_sel_t sel);
    case (sel)
      SEL_CRC12: return 12;
      SEL_CRC16: return 16;
      SEL_CCITT: return 16;
      default:   return 3;
    endcase
  endfunction

  // Generator coefficients below the leading term.
  function automatic logic [31:0] sel_taps(input code_sel_t sel);
    case (sel)
      SEL_CRC12: return 32'h0000_080F;
      SEL_CRC16: return 32'h0000_8005;
      SEL_CCITT: return 32'h0000_1021;
      default:   return 32'h0000_0003;
    endcase
  endfunction

endpackage

// File: rtl/cyc_divider.sv
module cyc_divider #(
  parameter int R = 3,
  parameter logic [R-1:0] TAPS = 3'b011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step_in,
  input  logic         step_out,
  input  logic         din,
  output logic [R-1:0] rem
);

  logic         fb;
  logic [R-1:0] shifted;
  logic [R-1:0] next_div;

  // Premultiplied division: input bit enters at the top of the register.
  assign fb      = din ^ rem[R-1];
  assign shifted = rem << 1;

  generate
    for (genvar i = 0; i < R; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
        assign next_div[i] = shifted[i] ^ fb;
      end else begin : g_off
        assign next_div[i] = shifted[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem <= '0;
    else if (clr)      rem <= '0;
    else if (step_in)  rem <= next_div;
    else if (step_out) rem <= shifted;
  end

endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
  import cyc_pkg::*;
#(
  parameter int K = 4,
  parameter int R = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_check,
  input  logic s_valid,
  input  logic m_ready,
  output logic s_ready,
  output logic m_valid,
  output logic step_in,
  output logic step_out,
  output logic clr,
  output logic in_check,
  output logic report
);

  localparam int N  = K + R;
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_INFO = CW'(K - 1);
  localparam logic [CW-1:0] LAST_WORD = CW'(N - 1);
  localparam logic [CW-1:0] LAST_CHK  = CW'(R - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          first;
  logic          mode_eff;
  logic          in_last;

  assign first    = (phase == PH_DATA) && (cnt == '0);
  assign mode_eff = first ? mode_check : mode_q;
  assign in_last  = mode_eff ? (cnt == LAST_WORD) : (cnt == LAST_INFO);

  always_comb begin
    s_ready  = 1'b0;
    m_valid  = 1'b0;
    step_out = 1'b0;
    in_check = 1'b0;
    report   = 1'b0;
    case (phase)
      PH_DATA: begin
        if (mode_eff) begin
          s_ready = 1'b1;
        end else begin
          s_ready = m_ready;
          m_valid = s_valid;
        end
      end
      PH_CHECK: begin
        m_valid  = 1'b1;
        in_check = 1'b1;
        step_out = m_ready;
      end
      PH_REPORT: report = 1'b1;
      default: ;
    endcase
  end

  assign step_in = (phase == PH_DATA) && s_valid && s_ready;
  assign clr     = report || (step_out && (cnt == LAST_CHK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_DATA;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      case (phase)
        PH_DATA: begin
          if (step_in) begin
            if (first) mode_q <= mode_check;
            if (in_last) begin
              cnt   <= '0;
              phase <= mode_eff ? PH_REPORT : PH_CHECK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_CHECK: begin
          if (step_out) begin
            if (cnt == LAST_CHK) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: phase <= PH_DATA;
      endcase
    end
  end

endmodule

// File: rtl/cyclic_enc.sv
module cyclic_enc
  import cyc_pkg::*;
#(
  parameter code_sel_t CODE = SEL_HAM7,
  parameter int K = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_check,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit,
  output logic check_phase,
  output logic chk_done,
  output logic chk_err
);

  localparam int R = sel_degree(CODE);
  localparam logic [31:0] TAPS_ALL = sel_taps(CODE);
  localparam logic [R-1:0] TAPS = TAPS_ALL[R-1:0];

  logic         step_in;
  logic         step_out;
  logic         clr;
  logic [R-1:0] rem;

  cyc_seq #(.K(K), .R(R)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_check(mode_check),
    .s_valid(s_valid), .m_ready(m_ready),
    .s_ready(s_ready), .m_valid(m_valid),
    .step_in(step_in), .step_out(step_out), .clr(clr),
    .in_check(check_phase), .report(chk_done)
  );

  cyc_divider #(.R(R), .TAPS(TAPS)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .step_in(step_in), .step_out(step_out),
    .din(s_bit), .rem(rem)
  );

  assign m_bit   = check_phase ? rem[R-1] : s_bit;
  assign chk_err = chk_done && (|rem);

endmodule

// File: rtl/cyc_enc_chk.sv
module cyc_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic s_ready,
  input logic m_valid,
  input logic m_ready,
  input logic m_bit,
  input logic check_phase,
  input logic chk_done,
  input logic chk_err
);

  AST_CHECK_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    check_phase |-> !s_ready); // R3
  AST_CHECK_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    check_phase |-> m_valid); // R3
  AST_CHECK_HOLDS_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (check_phase && !m_ready) |=> (check_phase && $stable(m_bit))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done); // R7
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> (!m_valid && !s_ready)); // R7

endmodule

bind cyclic_enc cyc_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_bit(m_bit), .check_phase(check_phase),
  .chk_done(chk_done), .chk_err(chk_err)
);

// File: tb/sim_cyclic_enc.sv
`timescale 1ns/1ps
module sim_cyclic_enc;
  import cyc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic mode, s_valid, s_bit, m_ready;
  logic s_ready, m_valid, m_bit, check_phase, chk_done, chk_err;

  logic b_valid, b_bit, b_mready;
  logic b_sready, b_mvalid, b_mbit, b_phase, b_done, b_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cyclic_enc u0 (
    .clk(clk), .rst_n(rst_n), .mode_check(mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
    .check_phase(check_phase), .chk_done(chk_done), .chk_err(chk_err)
  );

  cyclic_enc #(.CODE(SEL_CCITT), .K(8)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_check(1'b0),
    .s_valid(b_valid), .s_ready(b_sready), .s_bit(b_bit),
    .m_valid(b_mvalid), .m_ready(b_mready), .m_bit(b_mbit),
    .check_phase(b_phase), .chk_done(b_done), .chk_err(b_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Remainder of v(x) (len coefficients) modulo g(x) of degree deg, by long division.
  function automatic logic [63:0] ref_rem(input logic [63:0] v, input int len, input int deg, input logic [63:0] g);
    logic [63:0] w = v;
    for (int i = len - 1; i >= deg; i--)
      if (w[i]) w = w ^ (g << (i - deg));
    return w & ((64'd1 << deg) - 64'd1);
  endfunction

  task automatic run_enc(input logic [3:0] info, input bit stall_out, input bit stall_in,
                         input bit flip_mode, input string req);
    logic [6:0]  got_cw = '0;
    logic [6:0]  got_ph = '0;
    logic [63:0] r;
    logic [6:0]  exp_cw;
    int got = 0;
    int sent = 0;
    int cyc = 0;
    r = ref_rem({57'd0, info, 3'b000}, 7, 3, 64'hB);
    exp_cw = {info, r[2:0]};
    while (got < 7 && cyc < 200) begin
      @(negedge clk);
      mode    = (flip_mode && sent > 0) ? 1'b1 : 1'b0;
      s_valid = (sent < 4) && !(stall_in && (cyc % 3 == 1));
      s_bit   = (sent < 4) ? info[3 - (sent % 4)] : 1'b0;
      m_ready = !(stall_out && (cyc % 2 == 1));
      #1;
      if (m_valid && m_ready) begin
        got_cw[6 - got] = m_bit;
        got_ph[6 - got] = check_phase;
        got++;
      end else if (stall_out && !m_ready && sent < 4) begin
        check(s_ready == 1'b0, "R5 s_ready low under back-pressure", 64'(s_ready), 64'd0);
      end
      if (s_valid && s_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    mode    = 1'b0;
    check(got_cw == exp_cw, req, 64'(got_cw), 64'(exp_cw));
    check(got_ph == 7'b0000111, {req, " R3 check_phase on last bits"}, 64'(got_ph), 64'h7);
  endtask

  task automatic run_chk(input logic [6:0] word, input string req);
    logic [63:0] r;
    int sent = 0;
    int cyc = 0;
    bit any_out = 0;
    r = ref_rem({57'd0, word}, 7, 3, 64'hB);
    while (sent < 7 && cyc < 100) begin
      @(negedge clk);
      mode    = 1'b1;
      s_valid = 1'b1;
      s_bit   = word[6 - (sent % 7)];
      m_ready = 1'b1;
      #1;
      if (m_valid) any_out = 1;
      if (s_ready) sent++;
      cyc++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    mode    = 1'b0;
    #1;
    check(!any_out, {req, " R7 no output beats"}, 64'(any_out), 64'd0);
    check(chk_done == 1'b1, {req, " R7 done pulse"}, 64'(chk_done), 64'd1);
    check(chk_err == (r != 0), {req, " R7 error flag"}, 64'(chk_err), 64'(r != 0));
    @(negedge clk);
    #1;
    check(chk_done == 1'b0 && chk_err == 1'b0, {req, " R7 single pulse"}, 64'({chk_done, chk_err}), 64'd0);
  endtask

  task automatic run_ccitt(input logic [7:0] info, input logic [15:0] exp_chk, input string req);
    logic [23:0] got = '0;
    logic [63:0] r;
    int n = 0;
    int sent = 0;
    r = ref_rem({40'd0, info, 16'd0}, 24, 16, 64'h11021);
    while (n < 24 && sent < 200) begin
      @(negedge clk);
      b_valid  = (n < 8);
      b_bit    = (n < 8) ? info[7 - (n % 8)] : 1'b0;
      b_mready = 1'b1;
      #1;
      if (b_mvalid && b_mready) begin
        got[23 - n] = b_mbit;
        n++;
      end
      sent++;
    end
    @(negedge clk);
    b_valid = 1'b0;
    check(got[23:16] == info, {req, " R2 info passthrough"}, 64'(got[23:16]), 64'(info));
    check(got[15:0] == exp_chk && 64'(exp_chk) == r, {req, " R9 CCITT check word"}, 64'(got[15:0]), r);
  endtask

  initial begin
    mode = 0; s_valid = 0; s_bit = 0; m_ready = 0;
    b_valid = 0; b_bit = 0; b_mready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!check_phase && !chk_done && !chk_err && !m_valid, "R1 reset state",
          64'({check_phase, chk_done, chk_err, m_valid}), 64'd0);

    run_enc(4'b0001, 0, 0, 0, "R4 d=1 codeword");
    run_enc(4'b0000, 0, 0, 0, "R4 d=0 codeword");
    run_enc(4'b1111, 0, 0, 0, "R2 R3 d=1111 codeword");
    run_enc(4'b1010, 1, 0, 0, "R5 output stall codeword");
    run_enc(4'b0110, 0, 1, 0, "R6 input gaps codeword");
    run_enc(4'b1101, 1, 1, 0, "R8 back-to-back frame A");
    run_enc(4'b0001, 0, 0, 0, "R8 back-to-back frame B");
    run_enc(4'b1001, 0, 0, 1, "R10 mode change mid-frame ignored");

    run_chk(7'b0001011, "clean word");
    run_chk(7'b0001111, "corrupted word");
    run_chk(7'b1111111, "all-ones word");
    run_enc(4'b0011, 0, 0, 0, "R8 encode after check");

    run_ccitt(8'h01, 16'h1021, "byte 01");
    run_ccitt(8'h00, 16'h0000, "byte 00");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule